// File: doc/BRIEF.md
# Event Monitor Counter Unit

This block counts events for performance monitoring. It holds a control word, two 32-bit event counters and one 32-bit cycle counter. Software reaches all four through a small register port: a 2-bit select, a write strobe, write data and combinational read data. Each event counter picks one line from a vector of up to 256 single-cycle event pulses through an 8-bit select. The cycle counter advances on every clock, or once every 64 enabled clocks when the prescale bit is set.

For sampling, software preloads a counter with the two's-complement negative of the sample period. When the counter wraps past all-ones, the matching overflow flag is set. A single level interrupt stays asserted for as long as any counter has both its overflow flag and its interrupt enable set. Software clears a flag by writing a one to its bit in the control word.

Top module: `evmon_top`

## Requirements
- R1: Control bit 0 is a global enable. While it is 0, no counter and no prescaler changes, except through a software write or a reset bit.
- R2: Writing a control word with bit 1 set clears both event counters to zero on that edge. Bit 1 is not stored and reads as 0.
- R3: Writing a control word with bit 2 set clears the cycle counter and the divide-by-64 prescaler on that edge. Bit 2 is not stored and reads as 0.
- R4: With control bit 3 clear, the cycle counter adds one on every enabled edge. With bit 3 set, it adds one only on every 64th enabled edge, counted by a 6-bit prescaler that runs only while enabled and wraps after the value 63.
- R5: Event counter 0 takes its event from the line chosen by control bits 27:20, and event counter 1 from the line chosen by bits 19:12. A counter adds one on an enabled edge where its chosen line is 1. A select at or above the number of event lines never counts.
- R6: A counter that adds one while holding 0xFFFFFFFF becomes 0 and sets its overflow flag: bit 8 for event counter 0, bit 9 for event counter 1, bit 10 for the cycle counter. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A wrap on the same edge as a clearing write still leaves the flag set.
- R7: irq_o is 1 exactly while some counter k has its flag set and its interrupt enable set. The enables are bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter.
- R8: Control bits 31:28, 11, 7, 2 and 1 always read as 0. A write of 0xFFFFFFFF followed by a read returns 0x0FFFF079.
- R9: Select 0 is the control word, 1 the cycle counter, 2 event counter 0 and 3 event counter 1. A write to a counter loads the write data, takes priority over an increment on the same edge, and raises no flag on that edge.
- R10: After reset, all four registers read 0 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register select |
| wr_en_i | input | 1 | Write strobe for the selected register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected register (combinational) |
| evt_i | input | NUM_EVT | Event pulse lines |
| irq_o | output | 1 | Level interrupt |

## Verification
Every register is readable, so a wrong counter value, prescaler phase or flag shows on rdata_o once that register is selected. It is off by one count, or wrong by one period in a flag, within a single clock of the faulty edge. The bench rotates the select on idle cycles, which keeps that delay to at most four cycles. A flag or enable that is wrong also shows on irq_o on the very next cycle. The prescaler has no read path of its own, so a wrong phase first appears up to 64 enabled cycles later as a cycle-counter step at the wrong edge. For this reason the bench runs well past several prescale periods.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 8;
  localparam int NUM_CNT = 3;  // 0: event 0, 1: event 1, 2: cycle

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CYC  = 2'd1,
    REG_EV0  = 2'd2,
    REG_EV1  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [SEL_W-1:0]   sel0;
    logic [SEL_W-1:0]   sel1;
    logic [NUM_CNT-1:0] ovf;
    logic [NUM_CNT-1:0] ien;
    logic               div;
    logic               en;
  } ctrl_t;

  localparam int B_EN   = 0;
  localparam int B_RSTE = 1;
  localparam int B_RSTC = 2;
  localparam int B_DIV  = 3;
  localparam int B_IEN  = 4;
  localparam int B_OVF  = 8;
  localparam int B_SEL1 = 12;
  localparam int B_SEL0 = 20;

  localparam logic [DATA_W-1:0] ZERO_MASK = 32'hF000_0886;
endpackage

// File: rtl/evmon_counter.sv
module evmon_counter #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             wrap_o
);
  logic [WIDTH-1:0] cnt_q;

  assign wrap_o = inc_i && !wr_i && !clr_i && (cnt_q == {WIDTH{1'b1}});
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wr_i)   cnt_q <= wdata_i;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  AST_WR_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_q == $past(wdata_i)); // R9
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !wr_i) |=> cnt_q == '0); // R2 R3
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !clr_i && !inc_i) |=> $stable(cnt_q)); // R1
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_q == '0); // R6
endmodule

// File: rtl/evmon_prescale.sv
module evmon_prescale #(
  parameter int PSC_W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  logic [PSC_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == {PSC_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  AST_PSC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(cnt_q)); // R4
  AST_PSC_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !tick_o); // R3
endmodule

// File: rtl/evmon_ctrl.sv
module evmon_ctrl
  import evmon_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_CNT-1:0] wrap_i,
  output ctrl_t              ctrl_o,
  output logic               clr_evt_o,
  output logic               clr_cyc_o,
  output logic [DATA_W-1:0]  rd_o
);
  ctrl_t ctrl_q;

  assign clr_evt_o = wr_i && wdata_i[B_RSTE];
  assign clr_cyc_o = wr_i && wdata_i[B_RSTC];
  assign ctrl_o    = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_i) begin
      ctrl_q.en   <= wdata_i[B_EN];
      ctrl_q.div  <= wdata_i[B_DIV];
      ctrl_q.ien  <= wdata_i[B_IEN +: NUM_CNT];
      ctrl_q.sel1 <= wdata_i[B_SEL1 +: SEL_W];
      ctrl_q.sel0 <= wdata_i[B_SEL0 +: SEL_W];
      ctrl_q.ovf  <= (ctrl_q.ovf & ~wdata_i[B_OVF +: NUM_CNT]) | wrap_i;
    end else begin
      ctrl_q.ovf  <= ctrl_q.ovf | wrap_i;
    end
  end

  assign rd_o = {4'b0, ctrl_q.sel0, ctrl_q.sel1, 1'b0, ctrl_q.ovf,
                 1'b0, ctrl_q.ien, ctrl_q.div, 2'b00, ctrl_q.en};

  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i != '0) |=> (ctrl_q.ovf & $past(wrap_i)) == $past(wrap_i)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> (ctrl_q.ovf & $past(ctrl_q.ovf)) == $past(ctrl_q.ovf)); // R6
endmodule

// File: rtl/evmon_top.sv
module evmon_top
  import evmon_pkg::*;
#(
  parameter int NUM_EVT = 256,
  parameter int PSC_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         addr_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               irq_o
);
  localparam int EXT_W = 2 ** SEL_W;

  ctrl_t              ctrl;
  logic               clr_evt, clr_cyc, psc_tick;
  logic [DATA_W-1:0]  ctrl_rd;
  logic [EXT_W-1:0]   evt_ext;
  logic [NUM_CNT-1:0] inc, wr_cnt, clr_cnt, wrap;
  logic [DATA_W-1:0]  cnt [NUM_CNT];
  logic               ctrl_wr;

  assign ctrl_wr = wr_en_i && (addr_i == REG_CTRL);

  evmon_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (ctrl_wr),
    .wdata_i   (wdata_i),
    .wrap_i    (wrap),
    .ctrl_o    (ctrl),
    .clr_evt_o (clr_evt),
    .clr_cyc_o (clr_cyc),
    .rd_o      (ctrl_rd)
  );

  evmon_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl.en),
    .clr_i  (clr_cyc),
    .tick_o (psc_tick)
  );

  // widen to full select range; unused lines stay 0
  always_comb begin
    evt_ext = '0;
    evt_ext[NUM_EVT-1:0] = evt_i;
  end

  assign inc[0] = ctrl.en && evt_ext[ctrl.sel0];
  assign inc[1] = ctrl.en && evt_ext[ctrl.sel1];
  assign inc[2] = ctrl.en && (!ctrl.div || psc_tick);

  assign wr_cnt[0] = wr_en_i && (addr_i == REG_EV0);
  assign wr_cnt[1] = wr_en_i && (addr_i == REG_EV1);
  assign wr_cnt[2] = wr_en_i && (addr_i == REG_CYC);

  assign clr_cnt = {clr_cyc, clr_evt, clr_evt};

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    evmon_counter #(.WIDTH(DATA_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_cnt[k]),
      .wdata_i (wdata_i),
      .clr_i   (clr_cnt[k]),
      .inc_i   (inc[k]),
      .cnt_o   (cnt[k]),
      .wrap_o  (wrap[k])
    );
  end

  always_comb begin
    unique case (addr_i)
      REG_CTRL: rdata_o = ctrl_rd;
      REG_CYC:  rdata_o = cnt[2];
      REG_EV0:  rdata_o = cnt[0];
      default:  rdata_o = cnt[1];
    endcase
  end

  assign irq_o = |(ctrl.ovf & ctrl.ien);

  AST_ZERO_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_CTRL) |-> (rdata_o & ZERO_MASK) == '0); // R8
  AST_IRQ_FROM_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wrap & ctrl.ien) != '0 && !ctrl_wr) |=> irq_o); // R7
endmodule

// File: tb/evmon_top_tb.sv
module evmon_top_tb;
  localparam int NEVT = 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  addr = 0;
  logic        we = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [NEVT-1:0] evt = 0;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evmon_top #(.NUM_EVT(NEVT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq));

  // reference model
  bit        m_en, m_div;
  bit [2:0]  m_ien, m_ovf;
  bit [7:0]  m_s0, m_s1;
  bit [31:0] m_cnt [3];
  int        m_psc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_div = 0; m_ien = 0; m_ovf = 0; m_s0 = 0; m_s1 = 0;
      foreach (m_cnt[k]) m_cnt[k] = 0;
      m_psc = 0;
    end else begin
      bit [2:0] hit, wrapped;
      bit [31:0] nx [3];
      hit[0] = m_en && (m_s0 < NEVT) && evt[m_s0];
      hit[1] = m_en && (m_s1 < NEVT) && evt[m_s1];
      hit[2] = m_en && (!m_div || m_psc == 63);
      wrapped = 0;
      for (int k = 0; k < 3; k++) begin
        nx[k] = m_cnt[k];
        if (hit[k]) begin
          if (m_cnt[k] == 32'hFFFF_FFFF) wrapped[k] = 1;
          nx[k] = m_cnt[k] + 1;
        end
      end
      if (m_en) m_psc = (m_psc + 1) % 64;
      if (we) begin
        case (addr)
          0: begin
            if (wdata[1]) begin nx[0] = 0; nx[1] = 0; wrapped[1:0] = 0; end
            if (wdata[2]) begin nx[2] = 0; wrapped[2] = 0; m_psc = 0; end
            m_ovf = m_ovf & ~wdata[10:8];
            m_en = wdata[0]; m_div = wdata[3]; m_ien = wdata[6:4];
            m_s1 = wdata[19:12]; m_s0 = wdata[27:20];
          end
          1: begin nx[2] = wdata; wrapped[2] = 0; end
          2: begin nx[0] = wdata; wrapped[0] = 0; end
          default: begin nx[1] = wdata; wrapped[1] = 0; end
        endcase
      end
      m_ovf = m_ovf | wrapped;
      for (int k = 0; k < 3; k++) m_cnt[k] = nx[k];
    end
  end

  function automatic bit [31:0] m_read(input bit [1:0] a);
    case (a)
      0: return {4'b0, m_s0, m_s1, 1'b0, m_ovf, 1'b0, m_ien, m_div, 2'b00, m_en};
      1: return m_cnt[2];
      2: return m_cnt[0];
      default: return m_cnt[1];
    endcase
  endfunction

  task automatic check(input bit [31:0] act, input bit [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      case (addr)
        0: check(rdata, m_read(addr), "R8 ctrl");
        1: check(rdata, m_read(addr), "R4 cycle");
        default: check(rdata, m_read(addr), "R5 event");
      endcase
      check({31'b0, irq}, {31'b0, |(m_ovf & m_ien)}, "R7 irq");
    end
  end

  task automatic wr(input bit [1:0] a, input bit [31:0] d);
    @(negedge clk); evt = 0; addr = a; we = 1; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input bit [1:0] a, output bit [31:0] d);
    @(negedge clk); evt = 0; we = 0; addr = a;
    #2 d = rdata;
  endtask

  task automatic run(input int n, input bit active);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      we = 0; addr = 2'(i);
      evt = active ? NEVT'($urandom) : '0;
    end
    @(negedge clk); evt = 0;
  endtask

  function automatic bit [31:0] cw(input bit en, input bit div, input bit [2:0] ien,
                                   input bit [7:0] s0, input bit [7:0] s1);
    return {4'b0, s0, s1, 4'b0, 1'b0, ien, div, 2'b00, en};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); check(v, 0, "R10 reset value");
    end
    check({31'b0, irq}, 0, "R10 irq after reset");
    run(8, 1);  // disabled: nothing counts (R1)
    rd(2, v); check(v, 0, "R1 disabled event counter");

    // R5 event counting on in-range selects
    wr(0, cw(1, 0, 0, 8'd3, 8'd9));
    run(40, 1);
    // R5 out-of-range select on counter 0
    wr(0, cw(1, 0, 3'b111, 8'd20, 8'd2));
    rd(2, v); run(30, 1); rd(2, v2);
    check(v2, v, "R5 out-of-range select holds");

    // R8 write-as-zero bits, R2 R3 reset bits
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); check(v, 32'h0FFF_F079, "R8 ctrl readback");
    rd(1, v); check(v, 0, "R3 cycle counter cleared");
    rd(2, v); check(v, 0, "R2 event counter 0 cleared");
    rd(3, v); check(v, 0, "R2 event counter 1 cleared");
    // R4 divide-by-64
    wr(0, cw(1, 1, 0, 8'd1, 8'd2) | 32'h4);
    run(140, 1);
    rd(1, v); check(v, 2, "R4 prescaled cycle count");

    // R6 overflow from preload
    wr(0, cw(1, 0, 3'b111, 8'd1, 8'd2));
    wr(2, 32'hFFFF_FFF0);
    wr(3, 32'hFFFF_FFF8);
    run(80, 1);
    // R6 wrap on same edge as clearing write
    wr(1, 32'hFFFF_FFFE);
    wr(0, cw(1, 0, 3'b111, 8'd1, 8'd2) | 32'h400);
    rd(0, v); check({31'b0, v[10]}, 1, "R6 wrap beats clear");
    check({31'b0, irq}, 1, "R7 irq with flag and enable");
    // R7 clear flags
    wr(0, cw(1, 0, 3'b111, 8'd1, 8'd2) | 32'h700);
    @(negedge clk); #2;
    check({31'b0, irq}, 0, "R7 irq after flag clear");
    // R7 flag without enable
    wr(0, cw(1, 0, 3'b000, 8'd1, 8'd2));
    wr(1, 32'hFFFF_FFFF);
    run(10, 1);
    rd(0, v); check({31'b0, v[10]}, 1, "R6 cycle flag set");
    check({31'b0, irq}, 0, "R7 no irq when enable clear");

    // R9 write priority over increment
    wr(1, 32'h0000_1234);
    rd(1, v); check(v, 32'h0000_1235, "R9 loaded then counted");

    // R1 disable holds counters
    wr(0, cw(0, 0, 0, 8'd1, 8'd2));
    rd(1, v); run(20, 1); rd(1, v2);
    check(v2, v, "R1 cycle counter held");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule